// File: doc/BRIEF.md
# Load Ordering Dependence Predictor

This block decides, for each load that enters the issue stage, whether the load may run ahead of older stores whose addresses are not yet known. It holds a direct-mapped table indexed by the load's instruction address. Each entry has a hold flag and a short partial tag. A load with no matching trained entry is predicted independent and may issue early. A load whose entry is trained and whose tag matches is predicted dependent. The issue logic must then keep that load back until every older store has completed. Because the load never speculates, it cannot cause an ordering flush.

When the memory pipeline finds that a speculatively issued load read memory before an older store to the same address, it reports the load's instruction address on the violation port. The block raises a one-cycle squash request for that load and everything younger. It also trains the load's entry: the entry is marked to hold and its tag is set to the load's tag. Later executions of the same load then wait instead of rolling back again. A global clear input drops every hold flag in one cycle, so that barriers learned long ago do not remain forever. Lookups return their answer one cycle after the request. The replay and flush machinery is outside this block.

Top module: `mdp_predictor`

## Requirements
- R1: Reset drives pred_valid, pred_hold and squash low and leaves every entry untrained, so every lookup after reset predicts speculate (pred_hold = 0).
- R2: A lookup of an untrained load yields pred_valid = 1 with pred_hold = 0 on the cycle after the request.
- R3: Each cycle with viol_valid high produces squash = 1 on the next cycle, with squash_pc equal to that viol_pc. A cycle without a violation produces squash = 0 on the next cycle, and back-to-back violations give back-to-back squashes.
- R4: After a violation trains a load, every later lookup of that same load address gives pred_hold = 1, for as many repeats as occur, until a clear or a retrain of the entry.
- R5: The table index is lookup_pc[7:2] (64 entries) and the partial tag is lookup_pc[11:8]. A lookup whose index matches a trained entry but whose tag differs predicts speculate. Training a different tag at that index replaces the old one.
- R6: Training one index leaves the predictions of every other index unchanged.
- R7: A cycle with clr_all high clears every hold flag, and lookups from the next cycle on predict speculate.
- R8: When a violation and a lookup name the same index in the same cycle, the lookup sees the entry's value from before the training. The next lookup sees the trained value.
- R9: When clr_all and a violation fall in the same cycle, the clear takes effect first, so the violating load's entry ends up trained and all others are cleared.
- R10: pred_valid on a cycle equals lookup_valid on the previous cycle, and pred_hold is 0 whenever pred_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | A load asks for a prediction this cycle |
| lookup_pc | input | 32 | Instruction address of the load being looked up |
| viol_valid | input | 1 | An ordering violation was detected this cycle |
| viol_pc | input | 32 | Instruction address of the violating load |
| clr_all | input | 1 | Clear every hold flag in the table |
| pred_valid | output | 1 | Prediction for the previous cycle's lookup is present |
| pred_hold | output | 1 | 1: wait for all older stores, 0: may speculate |
| squash | output | 1 | Squash the violating load and all younger instructions |
| squash_pc | output | 32 | Instruction address of the load to squash from |

## Verification
Training from the violation port and reading from the lookup port can hit the same table index in one cycle. Clearing and training can also coincide. The bench drives a violation and a lookup of the same load address together and expects speculate from that lookup and hold from the next one. It also drives clr_all together with a violation and expects the violating load to hold afterwards while a load trained earlier at another index speculates. A reference model in the bench applies the clear before the training and reads lookups before updates. The scoreboard compares every cycle's outputs against that model.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

    localparam int MDP_TAG_W = 4;

    typedef struct packed {
        logic                 hold;
        logic [MDP_TAG_W-1:0] tag;
    } mdp_entry_t;

    typedef struct packed {
        logic valid;
        logic hold;
    } mdp_pred_t;

endpackage

// File: rtl/mdp_pc_split.sv
module mdp_pc_split #(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 6,
    parameter int TAG_W   = 4
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    localparam int TAG_LSB = IDX_LSB + IDX_W;

    assign idx = pc[IDX_LSB +: IDX_W];
    assign tag = pc[TAG_LSB +: TAG_W];
endmodule

// File: rtl/mdp_table.sv
module mdp_table
    import mdp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output mdp_entry_t           rd_entry,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [MDP_TAG_W-1:0] wr_tag,
    input  logic                 clr
);
    localparam int ENTRIES = 1 << IDX_W;

    mdp_entry_t ent_arr [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        mdp_entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (clr) begin
                ent_d.hold = 1'b0;
            end
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_d.hold = 1'b1;
                ent_d.tag  = wr_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_arr[i] = ent_q;
    end

    assign rd_entry = ent_arr[rd_idx];
endmodule

// File: rtl/mdp_squash_reg.sv
module mdp_squash_reg #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            viol_valid,
    input  logic [PC_W-1:0] viol_pc,
    output logic            squash,
    output logic [PC_W-1:0] squash_pc
);
    typedef struct packed {
        logic            req;
        logic [PC_W-1:0] pc;
    } sq_state_t;

    sq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = viol_valid;
        if (viol_valid) begin
            st_d.pc = viol_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign squash    = st_q.req;
    assign squash_pc = st_q.pc;
endmodule

// File: rtl/mdp_predictor.sv
module mdp_predictor
    import mdp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lookup_valid,
    input  logic [PC_W-1:0] lookup_pc,
    input  logic            viol_valid,
    input  logic [PC_W-1:0] viol_pc,
    input  logic            clr_all,
    output logic            pred_valid,
    output logic            pred_hold,
    output logic            squash,
    output logic [PC_W-1:0] squash_pc
);
    logic [IDX_W-1:0]     lk_idx, vi_idx;
    logic [MDP_TAG_W-1:0] lk_tag, vi_tag;
    mdp_entry_t           lk_entry;
    mdp_pred_t            pred_d, pred_q;

    mdp_pc_split #(
        .PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(MDP_TAG_W)
    ) u_lk_split (
        .pc(lookup_pc), .idx(lk_idx), .tag(lk_tag)
    );

    mdp_pc_split #(
        .PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(MDP_TAG_W)
    ) u_vi_split (
        .pc(viol_pc), .idx(vi_idx), .tag(vi_tag)
    );

    mdp_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_entry (lk_entry),
        .wr_en    (viol_valid),
        .wr_idx   (vi_idx),
        .wr_tag   (vi_tag),
        .clr      (clr_all)
    );

    mdp_squash_reg #(.PC_W(PC_W)) u_squash (
        .clk        (clk),
        .rst_n      (rst_n),
        .viol_valid (viol_valid),
        .viol_pc    (viol_pc),
        .squash     (squash),
        .squash_pc  (squash_pc)
    );

    always_comb begin
        pred_d       = pred_q;
        pred_d.valid = lookup_valid;
        pred_d.hold  = lookup_valid && lk_entry.hold && (lk_entry.tag == lk_tag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else begin
            pred_q <= pred_d;
        end
    end

    assign pred_valid = pred_q.valid;
    assign pred_hold  = pred_q.hold;
endmodule

// File: rtl/mdp_predictor_chk.sv
module mdp_predictor_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lookup_valid,
    input logic            viol_valid,
    input logic [PC_W-1:0] viol_pc,
    input logic            clr_all,
    input logic            pred_valid,
    input logic            pred_hold,
    input logic            squash,
    input logic [PC_W-1:0] squash_pc
);
    logic clean_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_q <= 1'b1;
        end else if (viol_valid) begin
            clean_q <= 1'b0;
        end else if (clr_all) begin
            clean_q <= 1'b1;
        end
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> pred_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> (!pred_valid && !pred_hold));

    a_r3_squash_on_viol: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |=> (squash && (squash_pc == $past(viol_pc))));

    a_r3_no_spurious_squash: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_valid |=> !squash);

    // R1 and R7: with no training since reset or the last clear, nothing holds
    a_r7_clean_table_speculates: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && clean_q) |=> !pred_hold);
endmodule

bind mdp_predictor mdp_predictor_chk #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .viol_valid   (viol_valid),
    .viol_pc      (viol_pc),
    .clr_all      (clr_all),
    .pred_valid   (pred_valid),
    .pred_hold    (pred_hold),
    .squash       (squash),
    .squash_pc    (squash_pc)
);

// File: tb/mdp_predictor_tb_top.sv
module mdp_predictor_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [31:0] lookup_pc = '0;
    logic        viol_valid = 1'b0;
    logic [31:0] viol_pc = '0;
    logic        clr_all = 1'b0;
    logic        pred_valid, pred_hold, squash;
    logic [31:0] squash_pc;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          pv;
        bit          ph;
        bit          sq;
        logic [31:0] spc;
        string       req;
    } exp_t;

    exp_t sb_q[$];

    bit       m_hold [64];
    bit [3:0] m_tag  [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdp_predictor dut_i (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
        .viol_valid(viol_valid), .viol_pc(viol_pc), .clr_all(clr_all),
        .pred_valid(pred_valid), .pred_hold(pred_hold),
        .squash(squash), .squash_pc(squash_pc)
    );

    task automatic check1(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the model's expectation.
    task automatic step(input bit lv, input logic [31:0] lpc, input bit vv,
                        input logic [31:0] vpc, input bit cl, input string req);
        exp_t e;
        @(negedge clk);
        lookup_valid = lv; lookup_pc = lpc;
        viol_valid = vv; viol_pc = vpc; clr_all = cl;
        e.pv  = lv;
        e.ph  = lv && m_hold[lpc[7:2]] && (m_tag[lpc[7:2]] == lpc[11:8]);
        e.sq  = vv;
        e.spc = vpc;
        e.req = req;
        sb_q.push_back(e);
        if (cl) begin
            for (int i = 0; i < 64; i++) m_hold[i] = 1'b0;
        end
        if (vv) begin
            m_hold[vpc[7:2]] = 1'b1;
            m_tag[vpc[7:2]]  = vpc[11:8];
        end
    endtask

    task automatic look(input logic [31:0] pc, input string req);
        step(1'b1, pc, 1'b0, 32'h0, 1'b0, req);
    endtask

    task automatic viol(input logic [31:0] pc, input string req);
        step(1'b0, 32'h0, 1'b1, pc, 1'b0, req);
    endtask

    // Monitor: compare outputs just after each active edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check1(e.req, "pred_valid", {31'b0, pred_valid}, {31'b0, e.pv});
                check1(e.req, "pred_hold", {31'b0, pred_hold}, {31'b0, e.ph});
                check1(e.req, "squash", {31'b0, squash}, {31'b0, e.sq});
                if (e.sq) check1(e.req, "squash_pc", squash_pc, e.spc);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [31:0] PC_A  = 32'h0000_0104; // idx 1, tag 1
    localparam logic [31:0] PC_B  = 32'h0000_0204; // idx 1, tag 2
    localparam logic [31:0] PC_C  = 32'h0000_0308; // idx 2, tag 3
    localparam logic [31:0] PC_D  = 32'h0000_0F10; // idx 4, tag 15

    initial begin
        for (int i = 0; i < 64; i++) begin m_hold[i] = 1'b0; m_tag[i] = 4'h0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs low while in reset
        check1("R1", "pred_valid in reset", {31'b0, pred_valid}, 32'h0);
        check1("R1", "pred_hold in reset", {31'b0, pred_hold}, 32'h0);
        check1("R1", "squash in reset", {31'b0, squash}, 32'h0);
        rst_n = 1'b1;

        // R1, R2: every index speculates after reset
        for (int i = 0; i < 64; i++) look({20'h0, 4'(i % 16), 6'(i), 2'b00}, "R1");
        look(PC_A, "R2");

        // R3, R8: violation and lookup of the same load together
        step(1'b1, PC_A, 1'b1, PC_A, 1'b0, "R8");
        look(PC_A, "R8");
        // R4: repeated lookups keep holding
        look(PC_A, "R4");
        look(PC_A, "R4");
        look(PC_A, "R4");
        // R5: same index, other tag misses; R6: other index unaffected
        look(PC_B, "R5");
        look(PC_C, "R6");
        look(PC_D, "R6");
        // R3: back-to-back violations
        viol(PC_B, "R3");
        viol(PC_D, "R3");
        look(PC_A, "R5");
        look(PC_B, "R5");
        look(PC_D, "R4");
        look(PC_C, "R6");
        // R10: idle cycles
        step(1'b0, PC_B, 1'b0, 32'h0, 1'b0, "R10");
        step(1'b0, PC_D, 1'b0, 32'h0, 1'b0, "R10");
        // R7: clear drops all flags
        viol(PC_C, "R3");
        look(PC_C, "R4");
        step(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, "R7");
        look(PC_B, "R7");
        look(PC_C, "R7");
        look(PC_D, "R7");
        // R9: clear and training together
        viol(PC_C, "R9");
        step(1'b1, PC_C, 1'b1, PC_A, 1'b1, "R9");
        look(PC_A, "R9");
        look(PC_C, "R9");
        // Train every index, then read all, then clear and read all
        for (int i = 0; i < 64; i++) viol({20'h0, 4'((i * 7) % 16), 6'(i), 2'b00}, "R3");
        for (int i = 0; i < 64; i++) look({20'h0, 4'((i * 7) % 16), 6'(i), 2'b00}, "R4");
        for (int i = 0; i < 64; i++) look({20'h0, 4'((i * 7 + 1) % 16), 6'(i), 2'b00}, "R5");
        step(1'b0, 32'h0, 1'b0, 32'h0, 1'b1, "R7");
        for (int i = 0; i < 64; i++) look({20'h0, 4'((i * 7) % 16), 6'(i), 2'b00}, "R7");
        step(1'b0, 32'h0, 1'b0, 32'h0, 1'b0, "R10");

        @(posedge clk);
        #2;
        @(posedge clk);
        #2;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule